// File: doc/BRIEF.md
# Key-Guarded RAM Wipe Controller

This block clears a small on-chip RAM on command. Software reaches it through a simple word-addressed register bus with single-cycle read and write strobes. It drives the RAM's write port directly. The erase command is guarded. Software must first write a two-byte unlock sequence to a key register, and only then does a start request in the control register take effect.

Once an erase starts, the controller writes zero to one RAM word per clock, from the lowest address to the highest. It shows its progress in the control register. The start flag clears by itself when the last word is written. The key guard closes again as soon as an erase is accepted, and again when the erase finishes. Every further wipe therefore needs a fresh unlock sequence.

Top module: `wipe_ctrl`

## Requirements
- R1: After reset, the control register (word address 0) reads 0, no RAM write is issued, and the key guard is closed.
- R2: Writing 0xCA and then 0x53 to the key register (word address 1) opens the guard. A following control write with bit 0 set then starts an erase.
- R3: A key write that does not continue the sequence closes the guard. Examples are 0x53 without a preceding 0xCA, or any value other than 0xCA or 0x53.
- R4: A write of 0xCA while waiting for the second byte restarts the sequence. The new 0xCA counts as the first byte, so 0xCA, 0xCA, 0x53 opens the guard.
- R5: A control write with bit 0 set while the guard is closed has no effect. No RAM write follows, and the control register stays 0.
- R6: An accepted start makes the RAM write port write zero on consecutive clocks, starting on the clock after acceptance. Addresses run 0, 1, …, DEPTH-1, exactly one write per word, then the write enable drops.
- R7: During an erase, control bit 1 (busy) and control bit 0 (start) both read 1. Both read 0 once the last word has been written.
- R8: Accepting a start closes the guard. A second start without a new key sequence is ignored.
- R9: Control writes while busy is set are ignored. They neither restart nor lengthen the sweep.
- R10: Only bits 7:0 of a key write are compared. The upper bus bits are ignored.
- R11: Completion of an erase closes the guard even if the key sequence finishes in the final erase cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | REG_AW | Register word address (0 control, 1 key) |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Registered read data, valid the cycle after bus_rd |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | $clog2(DEPTH) | RAM word address |
| mem_wdata | output | DATA_W | RAM write data (always zero during a wipe) |

## Verification
Two functions can land on the same clock: completion of the sweep, and bus writes that would otherwise change the guard or the start flag. The bench provokes this directly. It finishes a valid key sequence in the last two erase cycles, and in another run it writes the start bit mid-sweep. It then checks that the sweep length stays DEPTH, that the flags read 0 afterwards, and that a later start is refused. Random key byte mixes are scored against a bench model of the guard.

// File: rtl/wipe_pkg.sv
package wipe_pkg;
  typedef enum logic [1:0] {
    KS_SHUT  = 2'd0,
    KS_HALF  = 2'd1,
    KS_OPEN  = 2'd2
  } key_state_t;

  localparam logic [7:0] KEY_BYTE_A = 8'hCA;
  localparam logic [7:0] KEY_BYTE_B = 8'h53;

  localparam int CTRL_WORD = 0;
  localparam int KEY_WORD  = 1;
  localparam int START_POS = 0;
  localparam int BUSY_POS  = 1;
endpackage

// File: rtl/wipe_key_lock.sv
module wipe_key_lock
  import wipe_pkg::*;
#(
  parameter int KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_byte,
  input  logic             relock,
  output logic             unlocked
);
  key_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_wr) begin
      if (key_byte == KEY_W'(KEY_BYTE_A))
        state_d = KS_HALF;
      else if (key_byte == KEY_W'(KEY_BYTE_B) && state_q == KS_HALF)
        state_d = KS_OPEN;
      else
        state_d = KS_SHUT;
    end
    if (relock)
      state_d = KS_SHUT;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= KS_SHUT;
    else     state_q <= state_d;
  end

  assign unlocked = (state_q == KS_OPEN);

  // R3
  wrong_key_chk: assert property (@(posedge clk) disable iff (rst)
    (key_wr && key_byte != KEY_W'(KEY_BYTE_A) && key_byte != KEY_W'(KEY_BYTE_B))
      |=> !unlocked);

  // R8
  relock_chk: assert property (@(posedge clk) disable iff (rst)
    relock |=> !unlocked);
endmodule

// File: rtl/wipe_sweeper.sv
module wipe_sweeper #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  output logic              busy,
  output logic              finishing,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          active_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      addr_q   <= '0;
    end else if (active_q) begin
      if (addr_q == LAST) begin
        active_q <= 1'b0;
        addr_q   <= '0;
      end else begin
        addr_q <= addr_q + AW'(1);
      end
    end else if (go) begin
      active_q <= 1'b1;
      addr_q   <= '0;
    end
  end

  assign busy      = active_q;
  assign finishing = active_q && (addr_q == LAST);
  assign mem_we    = active_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = '0;

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  // R6
  sweep_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> (mem_addr == '0));
endmodule

// File: rtl/wipe_regs.sv
module wipe_regs
  import wipe_pkg::*;
#(
  parameter int REG_AW = 2,
  parameter int BUS_W  = 32,
  parameter int KEY_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              unlocked,
  input  logic              busy,
  input  logic              finishing,
  output logic              go,
  output logic              start_flag,
  output logic              key_wr,
  output logic [KEY_W-1:0]  key_byte,
  output logic [BUS_W-1:0]  bus_rdata
);
  logic             start_q;
  logic [BUS_W-1:0] rdata_q;
  logic             ctrl_sel;

  assign ctrl_sel = (bus_addr == REG_AW'(CTRL_WORD));
  assign key_wr   = bus_wr && (bus_addr == REG_AW'(KEY_WORD));
  assign key_byte = bus_wdata[KEY_W-1:0];
  assign go       = bus_wr && ctrl_sel && bus_wdata[START_POS] && unlocked && !busy;

  always_ff @(posedge clk) begin
    if (rst)            start_q <= 1'b0;
    else if (finishing) start_q <= 1'b0;
    else if (go)        start_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= '0;
      if (ctrl_sel) begin
        rdata_q[START_POS] <= start_q;
        rdata_q[BUSY_POS]  <= busy;
      end
    end
  end

  assign start_flag = start_q;
  assign bus_rdata  = rdata_q;

  // R7
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    finishing |=> !start_flag);
endmodule

// File: rtl/wipe_ctrl.sv
module wipe_ctrl
  import wipe_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int BUS_W  = 32,
  parameter int REG_AW = 2,
  localparam int KEY_W = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  logic             unlocked;
  logic             busy;
  logic             finishing;
  logic             go;
  logic             start_flag;
  logic             key_wr;
  logic [KEY_W-1:0] key_byte;

  wipe_regs #(.REG_AW(REG_AW), .BUS_W(BUS_W), .KEY_W(KEY_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .unlocked(unlocked), .busy(busy), .finishing(finishing),
    .go(go), .start_flag(start_flag), .key_wr(key_wr), .key_byte(key_byte),
    .bus_rdata(bus_rdata)
  );

  wipe_key_lock #(.KEY_W(KEY_W)) u_lock (
    .clk(clk), .rst(rst),
    .key_wr(key_wr), .key_byte(key_byte),
    .relock(go || finishing),
    .unlocked(unlocked)
  );

  wipe_sweeper #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_sweep (
    .clk(clk), .rst(rst), .go(go),
    .busy(busy), .finishing(finishing),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // R5
  erase_needs_key_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(unlocked));

  // R7
  busy_flag_pair_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> start_flag);

  // R11
  done_relock_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !unlocked);
endmodule

// File: tb/wipe_ctrl_test.sv
module wipe_ctrl_test;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;

  int checks = 0;
  int fails  = 0;
  int kstate = 0;
  logic [31:0] ram [DEPTH];

  always #5 clk = ~clk;

  wipe_ctrl #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always @(negedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

  function automatic int next_key(int s, logic [7:0] b);
    if (b == 8'hCA) return 1;
    if (b == 8'h53 && s == 1) return 2;
    return 0;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send_key(logic [31:0] d);
    wr(2'd1, d);
    kstate = next_key(kstate, d[7:0]);
  endtask

  task automatic run_sweep(bit inj_ctrl, bit inj_key);
    logic [31:0] r;
    int bad = 0;
    for (int k = 0; k < DEPTH; k++) begin
      check(mem_we && mem_addr == AW'(k) && mem_wdata == 0, "R6 sweep step",
            {mem_we, mem_addr}, {1'b1, AW'(k)});
      if (k == 3) check(bus_rdata == 32'd3, "R7 flags mid-erase", bus_rdata, 3);
      bus_wr = 1'b0; bus_rd = 1'b0;
      if (k == 2) begin bus_rd = 1'b1; bus_addr = 2'd0; end
      if (inj_ctrl && k == 5) begin bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 32'd1; end
      if (inj_key && k == DEPTH-2) begin bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 32'hCA; end
      if (inj_key && k == DEPTH-1) begin bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h53; end
      @(negedge clk);
    end
    bus_wr = 1'b0; bus_rd = 1'b0;
    check(!mem_we, "R9 sweep length is DEPTH", mem_we, 0);
    kstate = 0;
    rd(2'd0, r);
    check(r == 0, "R7 flags clear after erase", r, 0);
    for (int i = 0; i < DEPTH; i++) if (ram[i] != 0) bad++;
    check(bad == 0, "R6 all words zero", bad, 0);
  endtask

  task automatic try_start(string req, bit inj_ctrl, bit inj_key);
    logic [31:0] r;
    bit exp = (kstate == 2);
    for (int i = 0; i < DEPTH; i++) ram[i] = 32'hA5A5_0000 | i;
    wr(2'd0, 32'd1);
    check(mem_we == exp, req, mem_we, exp);
    if (exp) begin
      run_sweep(inj_ctrl, inj_key);
    end else begin
      rd(2'd0, r);
      check(r == 0 && !mem_we, {req, " ignored"}, r, 0);
    end
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    check(!mem_we, "R1 no write after reset", mem_we, 0);
    rd(2'd0, r);
    check(r == 0, "R1 control reads zero", r, 0);
    try_start("R1 guard closed after reset", 0, 0);
    // R5
    try_start("R5 start while locked", 0, 0);
    // R3 lone second byte
    send_key(32'h53);
    try_start("R3 lone 0x53", 0, 0);
    // R3 wrong byte between
    send_key(32'hCA); send_key(32'h11); send_key(32'h53);
    try_start("R3 wrong byte breaks sequence", 0, 0);
    // R2 + R9
    send_key(32'hCA); send_key(32'h53);
    try_start("R2 unlock then start", 1, 0);
    // R8
    try_start("R8 second start without key", 0, 0);
    // R4 + R11
    send_key(32'hCA); send_key(32'hCA); send_key(32'h53);
    try_start("R4 repeated first byte", 0, 1);
    try_start("R11 key in last cycle relocked", 0, 0);
    // R10
    send_key(32'hFFFF_FFCA); send_key(32'h1234_5653);
    try_start("R10 upper key bits ignored", 0, 0);
    // random key mixes
    for (int it = 0; it < 40; it++) begin
      int n = 1 + ($urandom % 3);
      for (int j = 0; j < n; j++) begin
        int sel = $urandom % 3;
        logic [31:0] b = (sel == 0) ? 32'hCA : (sel == 1) ? 32'h53 : $urandom;
        send_key(b);
      end
      try_start("R3 random key mix", 0, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule